// File: doc/BRIEF.md
# Flash Completion Polling Engine

This block runs on the host side of a parallel flash device. Once software or another engine has written the last strobe of a program or erase command sequence, it pulses `start_i` together with the kind of operation, the address to poll and, for a program, the byte that was written. The engine then reads the device through a simple request/valid read port. It keeps reading until bit 7 of the returned byte shows that the embedded operation has finished, or until the operation is judged to have failed.

While a program is running, bit 7 reads as the inverse of bit 7 of the written byte, and it takes the true value once the program is complete. While an erase is running, bit 7 reads 0, and it reads 1 once the erase is complete. Bit 7 can settle before the lower bits do, so a match on bit 7 is always followed by one more full read, and that confirming read decides the result. Bit 5 set means the device has exceeded its internal time limit. Bit 7 may still have flipped at the same moment, so the engine reads once more before it reports failure.

A poll budget set by a parameter bounds the loop, so a device that never answers cannot hang the engine. The result is reported as a `done_o` or `fail_o` level, together with the byte that decided it. Both stay put until the next accepted start.

Top module: `dq7_poll_engine`

## Requirements
- R1: After reset, `rd_req_o`, `done_o` and `fail_o` are 0, and the engine stays idle and issues no read until `start_i` is seen high.
- R2: A start is accepted only when no operation is running. On acceptance the engine captures `op_erase_i`, `poll_addr_i` and `exp_data_i`, and every read of that operation presents the captured address on `rd_addr_o`. A start pulse during a running operation has no effect on its reads or its outcome.
- R3: A read is requested by holding `rd_req_o` high, with `rd_addr_o` stable, until a cycle in which `rd_valid_i` is high. That cycle completes exactly one read and captures `rd_data_i`.
- R4: Bit 7 of a poll byte is compared with a target. For a program (`op_erase_i`=0) the target is bit 7 of the expected byte; for an erase (`op_erase_i`=1) the target is 1. A mismatch with bit 5 clear and the budget not used up leads to another poll read.
- R5: A bit 7 match is followed by exactly one confirming read. A program reports done only if the confirming byte equals the expected byte, and fails otherwise. An erase reports done if bit 7 of the confirming byte is 1, and fails otherwise. `result_o` is the confirming byte.
- R6: A poll byte with a bit 7 mismatch and bit 5 set leads to one recheck read. If bit 7 of the recheck matches the target, the confirming read of R5 follows. Otherwise the engine fails with `result_o` equal to the recheck byte.
- R7: When the MAX_POLLS-th poll read has neither a bit 7 match nor bit 5 set, the engine fails with `result_o` equal to that byte. A match, or bit 5 set, on that last poll read is still handled as in R5 and R6.
- R8: `done_o` and `fail_o` are never high together. Neither is high while a read is requested. The one that is set stays high until the next accepted start, and both are 0 in the cycle after that start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (after the final command write) |
| op_erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| poll_addr_i | input | ADDR_W | Address to poll (programmed byte or address in the erasing sector) |
| exp_data_i | input | 8 | Byte that was programmed (unused for erase) |
| rd_req_o | output | 1 | Read request, held until accepted |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid; completes the current read |
| rd_data_i | input | 8 | Read data byte |
| done_o | output | 1 | Operation completed successfully |
| fail_o | output | 1 | Operation failed (time limit, bad data, or budget exhausted) |
| result_o | output | 8 | Byte that decided the outcome |

## Verification
The hardest situations to reach are the ones where the device's answer changes exactly at a decision point. One is a byte whose bit 7 is already correct while the low bits are not. Another is bit 5 rising one read before bit 7 flips. A third is success arriving on the very last read the budget allows. The bench reaches all of them with a behavioural flash responder that replays a scripted byte sequence, one byte per accepted read, with a fixed response latency. Each script is laid out so that the mixed byte, the bit 5 byte or the matching byte lands on a chosen read index. The scoreboard then checks the outcome flag, the deciding byte and the exact number of reads, which shows whether the confirming read and the recheck read happened.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam int BYTE_W   = 8;
    localparam int RDY_BIT  = 7;   // completion indicator
    localparam int TLIM_BIT = 5;   // time-limit-exceeded indicator

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_CHECK   = 3'd2,
        ST_RECHECK = 3'd3,
        ST_CONFIRM = 3'd4,
        ST_DONE    = 3'd5,
        ST_FAIL    = 3'd6
    } poll_state_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } poll_op_e;

endpackage

// File: rtl/poll_budget.sv
module poll_budget #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic exhausted_o
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign exhausted_o = (cnt_q >= LIMIT);

endmodule

// File: rtl/dq7_judge.sv
module dq7_judge
    import poll_pkg::*;
(
    input  poll_op_e            op_i,
    input  logic [BYTE_W-1:0]   exp_i,
    input  logic [BYTE_W-1:0]   data_i,
    output logic                rdy_match_o,
    output logic                tlim_o,
    output logic                final_ok_o
);
    logic target;

    always_comb begin
        target      = (op_i == OP_ERASE) ? 1'b1 : exp_i[RDY_BIT];
        rdy_match_o = (data_i[RDY_BIT] == target);
        tlim_o      = data_i[TLIM_BIT];
        if (op_i == OP_ERASE) final_ok_o = data_i[RDY_BIT];
        else                  final_ok_o = (data_i == exp_i);
    end

endmodule

// File: rtl/dq7_poll_engine.sv
module dq7_poll_engine
    import poll_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int MAX_POLLS = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [ADDR_W-1:0] poll_addr_i,
    input  logic [7:0]        exp_data_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [7:0]        rd_data_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [7:0]        result_o
);
    typedef struct packed {
        poll_state_e         state;
        poll_op_e            op;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   exp_b;
        logic [BYTE_W-1:0]   rdata;
        logic [BYTE_W-1:0]   result;
        logic                done;
        logic                fail;
    } regs_t;

    regs_t r_d, r_q;

    logic              cnt_clr, cnt_inc, budget_out;
    logic [BYTE_W-1:0] judge_in;
    logic              j_match, j_tlim, j_ok;

    // Bytes held from a poll are judged in CHECK; recheck/confirm judge live data.
    assign judge_in = (r_q.state == ST_CHECK) ? r_q.rdata : rd_data_i;

    dq7_judge u_judge (
        .op_i        (r_q.op),
        .exp_i       (r_q.exp_b),
        .data_i      (judge_in),
        .rdy_match_o (j_match),
        .tlim_o      (j_tlim),
        .final_ok_o  (j_ok)
    );

    poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (cnt_clr),
        .inc_i       (cnt_inc),
        .exhausted_o (budget_out)
    );

    always_comb begin
        r_d     = r_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (r_q.state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    r_d.state = ST_READ;
                    r_d.op    = op_erase_i ? OP_ERASE : OP_PROG;
                    r_d.addr  = poll_addr_i;
                    r_d.exp_b = exp_data_i;
                    r_d.done  = 1'b0;
                    r_d.fail  = 1'b0;
                    cnt_clr   = 1'b1;
                end
            end
            ST_READ: begin
                if (rd_valid_i) begin
                    r_d.rdata = rd_data_i;
                    r_d.state = ST_CHECK;
                    cnt_inc   = 1'b1;
                end
            end
            ST_CHECK: begin
                if (j_match) begin
                    r_d.state = ST_CONFIRM;
                end else if (j_tlim) begin
                    r_d.state = ST_RECHECK;
                end else if (budget_out) begin
                    r_d.state  = ST_FAIL;
                    r_d.fail   = 1'b1;
                    r_d.result = r_q.rdata;
                end else begin
                    r_d.state = ST_READ;
                end
            end
            ST_RECHECK: begin
                if (rd_valid_i) begin
                    r_d.rdata = rd_data_i;
                    if (j_match) begin
                        r_d.state = ST_CONFIRM;
                    end else begin
                        r_d.state  = ST_FAIL;
                        r_d.fail   = 1'b1;
                        r_d.result = rd_data_i;
                    end
                end
            end
            ST_CONFIRM: begin
                if (rd_valid_i) begin
                    r_d.rdata  = rd_data_i;
                    r_d.result = rd_data_i;
                    if (j_ok) begin
                        r_d.state = ST_DONE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_FAIL;
                        r_d.fail  = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.op     <= OP_PROG;
            r_q.addr   <= '0;
            r_q.exp_b  <= '0;
            r_q.rdata  <= '0;
            r_q.result <= '0;
            r_q.done   <= 1'b0;
            r_q.fail   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_o  = (r_q.state == ST_READ) || (r_q.state == ST_RECHECK)
                    || (r_q.state == ST_CONFIRM);
    assign rd_addr_o = r_q.addr;
    assign done_o    = r_q.done;
    assign fail_o    = r_q.fail;
    assign result_o  = r_q.result;

endmodule

// File: rtl/poll_engine_chk.sv
module poll_engine_chk #(
    parameter int ADDR_W    = 19,
    parameter int MAX_POLLS = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_valid_i,
    input logic              done_o,
    input logic              fail_o
);
    localparam int unsigned READ_CAP = MAX_POLLS + 2;

    int unsigned rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt <= 0;
        end else if (start_i && !rd_req_o) begin
            rd_cnt <= 0;
        end else if (rd_req_o && rd_valid_i && (rd_cnt != 32'hFFFF_FFFF)) begin
            rd_cnt <= rd_cnt + 1;
        end
    end

    // R3: request held until accepted
    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> rd_req_o);

    // R3/R2: address stable while waiting
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> $stable(rd_addr_o));

    // R8: outcome flags exclusive
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    // R8: no reads once an outcome is reported
    p_quiet_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> !rd_req_o);

    // R8: done sticks until a new start
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R8: fail sticks until a new start
    p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o);

    // R7: bounded number of reads per operation
    p_read_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= READ_CAP);

endmodule

bind dq7_poll_engine poll_engine_chk #(
    .ADDR_W    (ADDR_W),
    .MAX_POLLS (MAX_POLLS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .done_o     (done_o),
    .fail_o     (fail_o)
);

// File: tb/dq7_poll_engine_tb.sv
module dq7_poll_engine_tb;
    localparam int AW   = 19;
    localparam int MAXP = 6;
    localparam int LAT  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic op_erase = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [7:0] expd = '0;
    logic rd_req;
    logic [AW-1:0] rd_addr;
    logic rd_valid = 1'b0;
    logic [7:0] rd_data = '0;
    logic done, fail;
    logic [7:0] result;

    always #5 clk = ~clk;

    dq7_poll_engine #(.ADDR_W(AW), .MAX_POLLS(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_erase_i(op_erase),
        .poll_addr_i(paddr), .exp_data_i(expd), .rd_req_o(rd_req),
        .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
        .done_o(done), .fail_o(fail), .result_o(result)
    );

    typedef struct packed {
        logic        fail;
        logic [7:0]  res;
        logic [15:0] reads;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] resp_q[$];
    logic [7:0] last_b = 8'h00;
    logic [AW-1:0] cur_addr = '0;
    string cur_tag = "";
    int reads = 0, addr_err = 0, req_drop = 0, wait_cnt = 0;
    int total = 0, failed = 0, ops_seen = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // behavioural flash responder: one scripted byte per accepted read
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_valid = 1'b0;
        end else if (rd_req) begin
            if (wait_cnt == LAT) begin
                wait_cnt = 0;
                if (resp_q.size() > 0) last_b = resp_q.pop_front();
                rd_data  = last_b;
                rd_valid = 1'b1;
                reads++;
                if (rd_addr != cur_addr) addr_err++;
            end else begin
                wait_cnt++;
            end
        end else if (wait_cnt != 0) begin
            req_drop++;
            wait_cnt = 0;
        end
    end

    // monitor: compare each reported outcome against the scoreboard
    logic flag_prev = 1'b0;
    always @(negedge clk) begin
        if ((done || fail) && !flag_prev && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(fail == e.fail, {cur_tag, " outcome"}, int'(fail), int'(e.fail));
            chk(done == !e.fail, {cur_tag, " done level"}, int'(done), int'(!e.fail));
            chk(result == e.res, {cur_tag, " result"}, int'(result), int'(e.res));
            chk(reads == int'(e.reads), {cur_tag, " read count"}, reads, int'(e.reads));
            chk(addr_err == 0, "R2 read address", addr_err, 0);
            chk(req_drop == 0, "R3 request held", req_drop, 0);
            ops_seen++;
        end
        flag_prev = done || fail;
    end

    // driver: push the expectation, start the operation, wait for its outcome
    task automatic run_op(input string tag, input bit erase, input logic [AW-1:0] a,
                          input logic [7:0] e, input bit xfail, input logic [7:0] xres,
                          input int xreads, input bit poke);
        int target;
        exp_t x;
        x.fail = xfail; x.res = xres; x.reads = 16'(xreads);
        exp_q.push_back(x);
        cur_tag = tag; cur_addr = a; reads = 0; addr_err = 0;
        target = ops_seen + 1;
        @(negedge clk);
        start = 1'b1; op_erase = erase; paddr = a; expd = e;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !fail, "R8 flags cleared after start", int'({done, fail}), 0);
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1; op_erase = ~erase; paddr = ~a; expd = ~e;
            @(negedge clk);
            start = 1'b0;
        end
        wait (ops_seen == target);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_req && !done && !fail, "R1 reset state", int'({rd_req, done, fail}), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(!rd_req && reads == 0, "R1 no read before start", reads, 0);

        // R2/R4 program, bit7=1, stray start mid-operation
        resp_q = '{8'h05, 8'h45, 8'h05, 8'hA5, 8'hA5};
        run_op("R2 prog A5", 1'b0, 19'h01234, 8'hA5, 1'b0, 8'hA5, 5, 1'b1);
        // R5 program, bit7=0, mixed byte then true data
        resp_q = '{8'hC3, 8'h83, 8'h43, 8'h3C};
        run_op("R5 prog 3C mixed", 1'b0, 19'h00010, 8'h3C, 1'b0, 8'h3C, 4, 1'b0);
        // R4 erase polarity
        resp_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h80, 8'hFF};
        run_op("R4 erase", 1'b1, 19'h70000, 8'h00, 1'b0, 8'hFF, 6, 1'b0);
        // R6 time limit then late success
        resp_q = '{8'h01, 8'h41, 8'h21, 8'h81, 8'h81};
        run_op("R6 late success", 1'b0, 19'h00200, 8'h81, 1'b0, 8'h81, 5, 1'b0);
        // R6 time limit confirmed failure
        resp_q = '{8'h40, 8'h20, 8'h60};
        run_op("R6 limit fail", 1'b1, 19'h10000, 8'h00, 1'b1, 8'h60, 3, 1'b0);
        // R5 confirming read mismatch
        resp_q = '{8'hC0, 8'h55, 8'h57};
        run_op("R5 confirm mismatch", 1'b0, 19'h00333, 8'h55, 1'b1, 8'h57, 3, 1'b0);
        // R7 budget exhausted
        resp_q = '{8'h92};
        run_op("R7 watchdog", 1'b0, 19'h00044, 8'h12, 1'b1, 8'h92, MAXP, 1'b0);
        // R5 erase immediate completion
        resp_q = '{8'hFF, 8'hFF};
        run_op("R5 erase immediate", 1'b1, 19'h20000, 8'h00, 1'b0, 8'hFF, 2, 1'b0);
        // R7 match on the last allowed poll
        resp_q = '{8'hC0, 8'hC0, 8'hC0, 8'hC0, 8'hC0, 8'h7E, 8'h7E};
        run_op("R7 last poll match", 1'b0, 19'h00555, 8'h7E, 1'b0, 8'h7E, MAXP + 1, 1'b0);
        // R7/R6 time limit on the last allowed poll, then success
        resp_q = '{8'h8F, 8'h8F, 8'h8F, 8'h8F, 8'h8F, 8'hA0, 8'h0F, 8'h0F};
        run_op("R7 last poll limit", 1'b0, 19'h00666, 8'h0F, 1'b0, 8'h0F, MAXP + 2, 1'b0);

        repeat (5) @(negedge clk);
        chk(done && !rd_req, "R8 outcome held", int'({done, rd_req}), 2);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule